// File: doc/BRIEF.md
# CRC-32 Frame Check Residue Verifier

This block decides whether a received frame arrived intact. Frame data comes in 64 bits per cycle, together with a per-byte lane mask and markers for the first and last word of the frame. The running CRC-32 register is started fresh at each frame start. Full words are folded in through a 64-bit parallel update network. The valid bytes of a short final word are folded in one byte per cycle through a separate 8-bit update network.

The frame's own check sequence is folded in along with the payload. When the last byte has been absorbed, the register is compared with the fixed residue of the polynomial. A good frame raises a one-cycle pass strobe and anything else raises a one-cycle fail strobe. The block sits beside a receive data path and reports one verdict per frame. It does not remove the check bytes and it keeps no counts.

Top module: `crc_residue_check`

## Requirements
- R1: The register uses x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1 in MSB-first form (0x04C11DB7). It is fed lane 0 first and, within each byte, bit 0 first. A frame whose last four bytes are the complement of its reflected CRC-32 (seed 0xFFFFFFFF), low byte first, leaves the register at 0xC704DD7B and raises `crc_ok`.
- R2: A frame with any bit changed leaves a different register value and raises `crc_bad`.
- R3: The register is set to 0xFFFFFFFF on every word that carries `in_sof`, so earlier traffic has no effect on the verdict.
- R4: When the final word has all eight lanes valid, it uses the 64-bit update, and the verdict strobe appears in the cycle after the clock edge that takes the word.
- R5: In the final word, the valid byte count k is the run of set `in_keep` bits starting at lane 0. Lanes above the first clear bit are ignored. For k in 1..7, byte 0 is folded on the edge that takes the word and the others on the next k-1 edges, so the verdict appears k-1 cycles later than in R4.
- R6: A final word with `in_keep[0]`=0 adds no bytes, and the verdict on the register as it stood appears with the timing of R4.
- R7: Each verdict is a single-cycle strobe. `crc_ok` and `crc_bad` are never high together, and each frame gets exactly one verdict.
- R8: A word with `in_sof` that arrives while a frame is open, or while a final word is still being folded, gives that frame a `crc_bad` strobe in the next cycle and starts the new frame from that word. If the new frame finishes on the same edge, its verdict follows one cycle later.
- R9: Valid words without `in_sof` are ignored while no frame is open and while a final word is still being folded.
- R10: The `in_keep` value of a word without `in_eof` is ignored, and all eight lanes are folded.
- R11: After reset both strobes are low and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word present on `in_data` |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_data | input | 64 | Frame bytes, lane j in bits 8j+7..8j |
| in_keep | input | 8 | Per-lane valid mask, bit j for lane j |
| crc_ok | output | 1 | One-cycle strobe: frame passed the residue check |
| crc_bad | output | 1 | One-cycle strobe: frame failed or was cut short |

## Verification
The bench sweeps frame lengths so that every final-word byte count from one to eight occurs, with and without a flipped bit. This catches a wrong bit order or lane order in either network (good frames would fail) and a miscounted tail (the strobe would arrive in the wrong cycle or carry the wrong verdict). It also drives a final word with a gap in its mask, an empty final word, and cleared masks on middle words. A design that counted all set bits, or that honoured the mask on middle words, would fold the wrong bytes and fail good frames. Aborts land both in the middle of a frame and during a tail, each followed by a one-word frame. A design without the one-slot delay would drop or merge a verdict, and a design that did not honour the restart would fail the new frame. Junk words sent while idle and during a tail expose a design that folds them.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

    localparam int unsigned CRC_W = 32;

    // verdict handed from the core to the output stage
    typedef struct packed {
        logic v;
        logic ok;
    } verdict_t;

endpackage

// File: rtl/crc_step.sv
// Parallel CRC update over W data bits, MSB-first register form.
// Data index 0 is the first bit on the wire (lane 0, bit 0).
module crc_step #(
    parameter int unsigned    W    = 64,
    parameter logic [31:0]    POLY = 32'h04C1_1DB7
) (
    input  logic [31:0]  crc_in,
    input  logic [W-1:0] data_in,
    output logic [31:0]  crc_out
);
    always_comb begin
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < int'(W); i++) begin
            fb = c[31] ^ data_in[i];
            c  = {c[30:0], 1'b0} ^ (fb ? POLY : 32'h0);
        end
        crc_out = c;
    end
endmodule

// File: rtl/crc_lane_count.sv
// Length of the run of set mask bits starting at lane 0.
module crc_lane_count #(
    parameter int unsigned LANES = 8,
    localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] keep_in,
    output logic [CNT_W-1:0] count_out
);
    always_comb begin
        logic run;
        run       = 1'b1;
        count_out = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            if (run && keep_in[i]) begin
                count_out = count_out + CNT_W'(1);
            end else begin
                run = 1'b0;
            end
        end
    end
endmodule

// File: rtl/crc_verdict_out.sv
// Turns abort and completion events into strobes, keeping order,
// with one slot for a second event that lands on the same edge.
module crc_verdict_out
    import crc_chk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic abort_ev,
    input  logic done_ev,
    input  logic done_ok,
    output logic ok_o,
    output logic bad_o,
    output logic pend_busy
);
    typedef struct packed {
        verdict_t pend;
        logic     ok;
        logic     bad;
    } vout_t;

    vout_t vq_q, vq_d;

    always_comb begin
        verdict_t first;
        vq_d  = '0;
        first = '0;
        if (vq_q.pend.v) begin
            first = vq_q.pend;
        end
        if (abort_ev) begin
            if (!first.v) begin
                first = '{v: 1'b1, ok: 1'b0};
            end else begin
                vq_d.pend = '{v: 1'b1, ok: 1'b0};
            end
        end
        if (done_ev) begin
            if (!first.v) begin
                first = '{v: 1'b1, ok: done_ok};
            end else begin
                vq_d.pend = '{v: 1'b1, ok: done_ok};
            end
        end
        vq_d.ok  = first.v & first.ok;
        vq_d.bad = first.v & ~first.ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vq_q <= '0;
        end else begin
            vq_q <= vq_d;
        end
    end

    assign ok_o      = vq_q.ok;
    assign bad_o     = vq_q.bad;
    assign pend_busy = vq_q.pend.v;
endmodule

// File: rtl/crc_residue_check.sv
module crc_residue_check #(
    parameter int unsigned DATA_W  = 64,
    parameter logic [31:0] POLY    = 32'h04C1_1DB7,
    parameter logic [31:0] SEED    = 32'hFFFF_FFFF,
    parameter logic [31:0] RESIDUE = 32'hC704_DD7B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W/8-1:0] in_keep,
    output logic              crc_ok,
    output logic              crc_bad
);
    import crc_chk_pkg::*;

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned CNT_W = $clog2(LANES + 1);
    localparam int unsigned IDX_W = $clog2(LANES);

    typedef struct packed {
        logic              open;
        logic              tail;
        logic [CRC_W-1:0]  crc;
        logic [DATA_W-1:0] tbuf;
        logic [IDX_W-1:0]  tidx;
        logic [CNT_W-1:0]  tleft;
    } core_t;

    core_t core_q, core_d;

    logic [CRC_W-1:0] base_crc, wide_out, head_out, tail_out;
    logic [7:0]       tail_byte;
    logic [CNT_W-1:0] nbytes;
    logic             abort_ev, done_ev, done_ok, take;
    logic             frm_open, tail_busy, pend_busy;

    assign base_crc  = in_sof ? SEED : core_q.crc;
    assign tail_byte = core_q.tbuf[core_q.tidx*8 +: 8];

    crc_step #(.W(DATA_W), .POLY(POLY)) u_wide (
        .crc_in (base_crc),
        .data_in(in_data),
        .crc_out(wide_out)
    );

    crc_step #(.W(8), .POLY(POLY)) u_head (
        .crc_in (base_crc),
        .data_in(in_data[7:0]),
        .crc_out(head_out)
    );

    crc_step #(.W(8), .POLY(POLY)) u_tail (
        .crc_in (core_q.crc),
        .data_in(tail_byte),
        .crc_out(tail_out)
    );

    crc_lane_count #(.LANES(LANES)) u_cnt (
        .keep_in  (in_keep),
        .count_out(nbytes)
    );

    always_comb begin
        core_d   = core_q;
        abort_ev = 1'b0;
        done_ev  = 1'b0;
        done_ok  = 1'b0;
        take     = in_valid && (in_sof || core_q.open);

        // byte-serial tail, unless a new frame start pre-empts it
        if (core_q.tail && !(in_valid && in_sof)) begin
            core_d.crc   = tail_out;
            core_d.tidx  = core_q.tidx + IDX_W'(1);
            core_d.tleft = core_q.tleft - CNT_W'(1);
            if (core_q.tleft == CNT_W'(1)) begin
                core_d.tail = 1'b0;
                done_ev     = 1'b1;
                done_ok     = (tail_out == RESIDUE);
            end
        end

        if (in_valid && in_sof && (core_q.open || core_q.tail)) begin
            abort_ev = 1'b1;
        end

        if (take) begin
            core_d.tail = 1'b0;
            if (!in_eof) begin
                core_d.open = 1'b1;
                core_d.crc  = wide_out;
            end else begin
                core_d.open = 1'b0;
                if (nbytes == CNT_W'(LANES)) begin
                    core_d.crc = wide_out;
                    done_ev    = 1'b1;
                    done_ok    = (wide_out == RESIDUE);
                end else if (nbytes == '0) begin
                    core_d.crc = base_crc;
                    done_ev    = 1'b1;
                    done_ok    = (base_crc == RESIDUE);
                end else begin
                    core_d.crc = head_out;
                    if (nbytes == CNT_W'(1)) begin
                        done_ev = 1'b1;
                        done_ok = (head_out == RESIDUE);
                    end else begin
                        core_d.tail  = 1'b1;
                        core_d.tbuf  = in_data;
                        core_d.tidx  = IDX_W'(1);
                        core_d.tleft = nbytes - CNT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q       <= '0;
            core_q.crc   <= SEED;
        end else begin
            core_q <= core_d;
        end
    end

    crc_verdict_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort_ev (abort_ev),
        .done_ev  (done_ev),
        .done_ok  (done_ok),
        .ok_o     (crc_ok),
        .bad_o    (crc_bad),
        .pend_busy(pend_busy)
    );

    assign frm_open  = core_q.open;
    assign tail_busy = core_q.tail;
endmodule

// File: rtl/crc_residue_check_sva.sv
module crc_residue_check_sva #(
    parameter int unsigned LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic             in_eof,
    input logic [LANES-1:0] in_keep,
    input logic             frm_open,
    input logic             tail_busy,
    input logic             pend_busy,
    input logic             abort_ev,
    input logic             done_ev,
    input logic             crc_ok,
    input logic             crc_bad
);
    // R7
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_ok && crc_bad));

    // R4 R6
    prompt_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && (in_sof || frm_open) &&
         (in_keep == {LANES{1'b1}} || !in_keep[0]))
        |=> (crc_ok || crc_bad));

    // R8
    abort_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && (frm_open || tail_busy)) |=> crc_bad);

    // R8
    pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_busy |=> (crc_ok || crc_bad));

    // R8
    pend_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend_busy && abort_ev && done_ev));

    // R9
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_open && !tail_busy && !pend_busy && !(in_valid && in_sof))
        |=> (!crc_ok && !crc_bad));

    // R5
    tail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_open && tail_busy));
endmodule

bind crc_residue_check crc_residue_check_sva #(.LANES(DATA_W / 8)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_keep  (in_keep),
    .frm_open (frm_open),
    .tail_busy(tail_busy),
    .pend_busy(pend_busy),
    .abort_ev (abort_ev),
    .done_ev  (done_ev),
    .crc_ok   (crc_ok),
    .crc_bad  (crc_bad)
);

// File: tb/sim_crc_residue_check.sv
module sim_crc_residue_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_keep = '0;
    logic        crc_ok, crc_bad;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic s_ok, s_bad;
    logic [7:0] fr [0:63];

    crc_residue_check u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .in_keep(in_keep),
        .crc_ok(crc_ok), .crc_bad(crc_bad)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // sample outputs at the falling edge, then drive the next word
    task automatic step(input bit v, input bit sof, input bit eof,
                        input logic [63:0] d, input logic [7:0] k);
        @(negedge clk);
        s_ok  = crc_ok;
        s_bad = crc_bad;
        in_valid = v; in_sof = sof; in_eof = eof; in_data = d; in_keep = k;
    endtask

    // n payload bytes plus the four check bytes; returns total length
    task automatic build(input int n, input int seed, output int len);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            fr[i] = 8'((seed * 37 + i * 13 + n * 5 + 1) & 255);
            c = c ^ {24'h0, fr[i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        c = ~c;
        fr[n]   = c[7:0];
        fr[n+1] = c[15:8];
        fr[n+2] = c[23:16];
        fr[n+3] = c[31:24];
        len = n + 4;
    endtask

    function automatic logic [63:0] word_of(input int len, input int w);
        logic [63:0] d;
        for (int j = 0; j < 8; j++)
            d[8*j +: 8] = (8*w + j < len) ? fr[8*w + j] : 8'(8'hC3 ^ (j * 29));
        return d;
    endfunction

    function automatic logic [7:0] mask_of(input int len, input int w);
        logic [7:0] m;
        for (int j = 0; j < 8; j++) m[j] = (8*w + j < len);
        return m;
    endfunction

    // sends a frame, then checks strobe timing and polarity
    task automatic send(input int len, input bit empty_end, input bit zero_mid,
                        input logic [7:0] extra_keep, input bit junk_tail,
                        input bit exp_ok, input string tag);
        int words, k, lat, seen;
        logic [7:0] m;
        words = (len + 7) / 8;
        k = len - 8 * (words - 1);
        seen = 0;
        for (int w = 0; w < words; w++) begin
            m = mask_of(len, w);
            if (w == words - 1) m = m | extra_keep;
            else if (zero_mid) m = 8'h00;
            step(1'b1, w == 0, (w == words - 1) && !empty_end, word_of(len, w), m);
            if (w > 0 && (s_ok || s_bad)) seen++;
        end
        if (empty_end) begin
            step(1'b1, 1'b0, 1'b1, 64'h5A5A_0F0F_1234_9876, 8'hFE);
            if (s_ok || s_bad) seen++;
        end
        lat = (empty_end || k == 8) ? 1 : k;
        chk(seen == 0, {tag, " no strobe inside frame"}, seen, 0);
        for (int j = 1; j <= lat + 1; j++) begin
            if (junk_tail && j < lat)
                step(1'b1, 1'b0, 1'b1, 64'hDEAD_BEEF_0BAD_F00D ^ 64'(j), 8'hFF);
            else
                step(1'b0, 1'b0, 1'b0, 64'h0, 8'h0);
            if (j < lat) begin
                if (s_ok || s_bad) seen++;
            end else if (j == lat) begin
                chk(s_ok == exp_ok && s_bad == !exp_ok, tag, {s_ok, s_bad},
                    {exp_ok, !exp_ok});
            end else begin
                chk(!s_ok && !s_bad, {tag, " single pulse R7"}, {s_ok, s_bad}, 0);
            end
        end
        if (lat > 1) chk(seen == 0, {tag, " early strobe R5"}, seen, 0);
    endtask

    // frame A cut by a one-word frame B; cut_in_tail picks where
    task automatic abort_case(input bit cut_in_tail, input string tag);
        int la, lb;
        logic [63:0] bw;
        build(20, 77, la);
        la = 15;                          // only used for word shapes below
        build(11, 5, la);                 // 15 bytes: final word has 7 lanes
        if (cut_in_tail) begin
            step(1'b1, 1'b1, 1'b0, word_of(la, 0), 8'hFF);
            step(1'b1, 1'b0, 1'b1, word_of(la, 1), mask_of(la, 1));
        end else begin
            step(1'b1, 1'b1, 1'b0, word_of(la, 0), 8'hFF);
        end
        build(4, 9, lb);                  // 8 bytes: one full word
        bw = word_of(lb, 0);
        step(1'b1, 1'b1, 1'b1, bw, 8'hFF);
        step(1'b0, 1'b0, 1'b0, 64'h0, 8'h0);
        chk(s_bad && !s_ok, {tag, " cut frame bad R8"}, {s_ok, s_bad}, 2'b01);
        step(1'b0, 1'b0, 1'b0, 64'h0, 8'h0);
        chk(s_ok && !s_bad, {tag, " new frame ok delayed R8 R3"}, {s_ok, s_bad}, 2'b10);
        step(1'b0, 1'b0, 1'b0, 64'h0, 8'h0);
        chk(!s_ok && !s_bad, {tag, " quiet after R7"}, {s_ok, s_bad}, 0);
    endtask

    initial begin
        int len;
        repeat (3) @(negedge clk);
        chk(!crc_ok && !crc_bad, "R11 strobes low in reset", {crc_ok, crc_bad}, 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 64'h0, 8'h0);
        chk(!s_ok && !s_bad, "R11 strobes low after reset", {s_ok, s_bad}, 0);

        // R9: words with no frame open are ignored
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF * 64'(i + 3), 8'hFF);
            if (i > 0) chk(!s_ok && !s_bad, "R9 idle word ignored", {s_ok, s_bad}, 0);
        end
        build(9, 1, len);
        send(len, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R3 R9 frame after junk");

        // R1 R2 R4 R5: every final-word byte count, good and damaged
        for (int n = 0; n < 28; n++) begin
            build(n, n + 2, len);
            send(len, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R1 R4 R5 good frame");
            fr[n / 2] = fr[n / 2] ^ 8'(1 << (n % 8));
            send(len, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R2 damaged frame");
        end
        build(40, 3, len);
        fr[len - 1] = fr[len - 1] ^ 8'h80;
        send(len, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R2 damaged check byte");

        // R5: mask with a gap, lanes past the gap ignored
        build(5, 11, len);                // 9 bytes, final word k=1
        send(len, 1'b0, 1'b0, 8'b1111_1100, 1'b0, 1'b1, "R5 gapped mask");
        build(10, 12, len);               // 14 bytes, final word k=6
        send(len, 1'b0, 1'b0, 8'b1000_0000, 1'b0, 1'b1, "R5 gapped mask k6");

        // R6: empty final word
        build(12, 13, len);
        send(len, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R6 empty final word");

        // R10: cleared masks on middle words
        build(25, 14, len);
        send(len, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, "R10 middle mask ignored");

        // R9: junk words during a tail
        build(9, 15, len);                // 13 bytes, final word k=5
        send(len, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R9 junk during tail");
        build(11, 16, len);               // 15 bytes, final word k=7
        send(len, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R9 junk during long tail");

        // R8: restart while open and while in a tail
        abort_case(1'b0, "R8 mid frame");
        abort_case(1'b1, "R8 in tail");

        build(6, 21, len);
        send(len, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R3 frame after aborts");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule